// File: doc/BRIEF.md
# DSI Command Packet Transmitter

This block turns one command request from a host controller into writes to the two transmit FIFOs of a DSI host: a 32-bit payload word FIFO and a 32-bit header FIFO. A request carries a data type and a 16-bit argument. For short and general command types the argument supplies the two parameter bytes. For long write types the argument is the byte count, and the bytes themselves arrive on a valid/ready byte stream.

For a long write, the bytes are packed into words and pushed first. The header is pushed after them. The block then waits for a FIFO-empty event from the host and reports completion. If that event does not arrive within a programmable number of cycles, it reports a timeout error. Requests made while the link sits in ultra-low-power state are refused, and so are data types the block does not know. Neither kind of refused request writes anything to the FIFOs.

Top module: `dsi_cmd_tx`

## Requirements
- R1: Payload bytes are packed little-endian. Byte n of a word goes to bits 8n+7:8n, so the first byte of the word lands in bits 7:0. Each full word is pushed with one `pl_wr` pulse.
- R2: When 1, 2 or 3 bytes remain, they form one final word whose unused upper bytes are zero. A length L gives exactly ceil(L/4) payload pushes.
- R3: In a long write, every payload push comes before the single header push. The header is one `hdr_wr` pulse.
- R4: A long-write header is {8'h00, length[15:8], length[7:0], data type}.
- R5: Short and general command types push only the header {8'h00, arg[15:8], arg[7:0], data type}. They push no payload and assert `done` in the same cycle as `hdr_wr`. These types are 0x03, 0x13, 0x23, 0x05, 0x15, 0x37, 0x02, 0x12, 0x22 and 0x32.
- R6: The long write types are 0x29 and 0x39. After the header, a `fifo_empty` pulse seen in any of the first `tmo_limit` wait cycles ends the request with a one-cycle `done`. Wait cycle 0 is the cycle in which `hdr_wr` is high. `done` and `err` are never high together.
- R7: If no `fifo_empty` pulse comes in those cycles, `err` pulses with `err_code` 3 exactly `tmo_limit` cycles after the `hdr_wr` cycle, and no `done` follows.
- R8: A request accepted while `link_ulps` is high gives `err` with `err_code` 1 and no FIFO write.
- R9: A request with any other data type gives `err` with `err_code` 2 and no FIFO write.
- R10: `busy` is high from the accept of a carried-out request until its `done` or `err`. While `busy` is high, `req_ready` is low. `byte_ready` is high only while payload is being collected.
- R11: After reset, `req_ready` is 1 and `busy`, `byte_ready`, `pl_wr`, `hdr_wr`, `done` and `err` are 0.
- R12: A long write of length 0 pushes only the header {8'h00, 8'h00, 8'h00, type} and then waits for `fifo_empty` as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_dtype | input | 8 | Packet data type |
| req_arg | input | LEN_W | Parameter bytes (short) or byte count (long) |
| link_ulps | input | 1 | Link in ultra-low-power state |
| tmo_limit | input | TO_W | Wait cycles allowed for the FIFO-empty event |
| byte_valid | input | 1 | Payload byte present |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Payload byte taken |
| pl_wr | output | 1 | Payload FIFO write strobe |
| pl_data | output | 32 | Payload FIFO word |
| hdr_wr | output | 1 | Header FIFO write strobe |
| hdr_data | output | 32 | Header FIFO word |
| fifo_empty | input | 1 | FIFO-empty event pulse |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request completed (pulse) |
| err | output | 1 | Request failed (pulse) |
| err_code | output | 2 | 1 ULPS, 2 unsupported type, 3 timeout |

## Verification
The bench builds the block with LEN_W = 16 and TO_W = 8, and programs a wait limit of 20 cycles. With that limit, a timeout happens within a short run, and an event arriving in the last allowed wait cycle can be tested as a boundary. The 16-bit length lets a 260-byte transfer give a nonzero high count byte. Random lengths below 40, with random gaps in the byte stream, cover every remainder of the final word.

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx #(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_dtype,
  input  logic [LEN_W-1:0] req_arg,
  input  logic             link_ulps,
  input  logic [TO_W-1:0]  tmo_limit,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             pl_wr,
  output logic [31:0]      pl_data,
  output logic             hdr_wr,
  output logic [31:0]      hdr_data,
  input  logic             fifo_empty,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code
);
  typedef enum logic [1:0] {S_IDLE, S_PAY, S_HDR, S_WAIT} st_t;
  st_t st;

  logic [7:0]       dt_q;
  logic [LEN_W-1:0] arg_q, rem;
  logic [1:0]       lane;
  logic [23:0]      acc;
  logic [TO_W-1:0]  tcnt;
  logic             long_q, is_short, is_long;
  logic [15:0]      arg16;
  logic [31:0]      word_nx;

  always_comb begin
    case (req_dtype)
      8'h03, 8'h13, 8'h23, 8'h05, 8'h15, 8'h37,
      8'h02, 8'h12, 8'h22, 8'h32: is_short = 1'b1;
      default:                    is_short = 1'b0;
    endcase
  end
  assign is_long    = (req_dtype == 8'h29) || (req_dtype == 8'h39);
  assign arg16      = 16'(arg_q);
  assign word_nx    = {8'h00, acc} | ({24'h0, byte_data} << {lane, 3'b000});
  assign req_ready  = (st == S_IDLE);
  assign byte_ready = (st == S_PAY);
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dt_q <= '0; arg_q <= '0; rem <= '0; lane <= '0; acc <= '0;
      tcnt <= '0; long_q <= 1'b0;
      pl_wr <= 1'b0; pl_data <= '0; hdr_wr <= 1'b0; hdr_data <= '0;
      done <= 1'b0; err <= 1'b0; err_code <= '0;
    end else begin
      pl_wr <= 1'b0; hdr_wr <= 1'b0; done <= 1'b0; err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          dt_q <= req_dtype; arg_q <= req_arg; rem <= req_arg;
          lane <= '0; acc <= '0; long_q <= is_long;
          if (link_ulps) begin
            err <= 1'b1; err_code <= 2'd1;
          end else if (!is_short && !is_long) begin
            err <= 1'b1; err_code <= 2'd2;
          end else if (is_long && req_arg != '0) st <= S_PAY;
          else st <= S_HDR;
        end
        S_PAY: if (byte_valid) begin
          rem <= rem - LEN_W'(1);
          if (lane == 2'd3 || rem == LEN_W'(1)) begin
            pl_wr <= 1'b1; pl_data <= word_nx; acc <= '0; lane <= '0;
          end else begin
            acc <= word_nx[23:0]; lane <= lane + 2'd1;
          end
          if (rem == LEN_W'(1)) st <= S_HDR;
        end
        S_HDR: begin
          hdr_wr <= 1'b1;
          hdr_data <= {8'h00, arg16[15:8], arg16[7:0], dt_q};
          tcnt <= '0;
          if (long_q) st <= S_WAIT;
          else begin done <= 1'b1; st <= S_IDLE; end
        end
        S_WAIT: begin
          if (fifo_empty) begin
            done <= 1'b1; st <= S_IDLE;
          end else if (tcnt == tmo_limit - TO_W'(1)) begin
            err <= 1'b1; err_code <= 2'd3; st <= S_IDLE;
          end else tcnt <= tcnt + TO_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsi_cmd_tx_chk.sv
module dsi_cmd_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        byte_ready,
  input logic        busy,
  input logic        pl_wr,
  input logic        hdr_wr,
  input logic [31:0] hdr_data,
  input logic        done,
  input logic        err,
  input logic [1:0]  err_code
);
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready); // R10
  AST_BYTES_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) byte_ready |-> busy); // R10
  AST_HDR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) hdr_wr |-> hdr_data[31:24] == 8'h00); // R4
  AST_NO_PAYLOAD_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n) hdr_wr |=> !pl_wr); // R3
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (done || err) |-> !busy); // R10
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n) err |-> err_code != 2'd0); // R8
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (err && err_code != 2'd3) |-> (!pl_wr && !hdr_wr)); // R9
endmodule

bind dsi_cmd_tx dsi_cmd_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .byte_ready(byte_ready),
  .busy(busy), .pl_wr(pl_wr), .hdr_wr(hdr_wr), .hdr_data(hdr_data),
  .done(done), .err(err), .err_code(err_code)
);

// File: tb/sim_dsi_cmd_tx.sv
`timescale 1ns/1ps
module sim_dsi_cmd_tx;
  localparam int LW = 16, TW = 8, LIM = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_dtype = '0;
  logic [LW-1:0] req_arg = '0;
  logic link_ulps = 1'b0;
  logic [TW-1:0] tmo_limit = TW'(LIM);
  logic byte_valid = 1'b0, byte_ready;
  logic [7:0] byte_data = '0;
  logic pl_wr, hdr_wr, fifo_empty = 1'b0, busy, done, err;
  logic [31:0] pl_data, hdr_data;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  dsi_cmd_tx #(.LEN_W(LW), .TO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dtype(req_dtype), .req_arg(req_arg), .link_ulps(link_ulps),
    .tmo_limit(tmo_limit), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .pl_wr(pl_wr), .pl_data(pl_data), .hdr_wr(hdr_wr),
    .hdr_data(hdr_data), .fifo_empty(fifo_empty), .busy(busy), .done(done),
    .err(err), .err_code(err_code));

  int nchk = 0, nfail = 0, cyc = 0;
  int npw, nhw, ndone, nerr, hdr_cyc, err_cyc, order_bad, acc_rdy, acc_busy;
  logic [31:0] pw [0:127];
  logic [31:0] hw;
  logic [1:0] ecode;
  logic [7:0] bb [0:511];

  always @(negedge clk) begin
    cyc++;
    if (pl_wr) begin pw[npw[6:0]] = pl_data; npw++; if (nhw > 0) order_bad = 1; end
    if (hdr_wr) begin hw = hdr_data; nhw++; hdr_cyc = cyc; end
    if (done) ndone++;
    if (err) begin nerr++; ecode = err_code; err_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input int len);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < len) w |= {24'h0, bb[4*k+j]} << (8*j);
    return w;
  endfunction

  task automatic do_req(input logic [7:0] dt, input int arg, input int nb, input int edly, input bit gappy);
    int i = 0, t = 0;
    bit a;
    for (int k = 0; k < nb; k++) bb[k] = 8'($urandom);
    @(negedge clk);
    npw = 0; nhw = 0; ndone = 0; nerr = 0; order_bad = 0; hdr_cyc = 0; err_cyc = 0;
    req_dtype = dt; req_arg = LW'(arg); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc_rdy = int'(req_ready); acc_busy = int'(busy);
    while (i < nb && t < 5000) begin
      byte_valid = gappy ? ($urandom % 3 != 0) : 1'b1;
      byte_data = bb[i];
      a = byte_valid && byte_ready;
      @(posedge clk);
      if (a) i++;
      t++;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    if (edly > 0) begin
      t = 0;
      while (nhw == 0 && t < 200) begin @(posedge clk); t++; end
      repeat (edly) @(negedge clk);
      fifo_empty = 1'b1;
      @(negedge clk);
      fifo_empty = 1'b0;
    end
    t = 0;
    while (ndone + nerr == 0 && t < 4*LIM + 100) begin @(posedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_long(input logic [7:0] dt, input int len, input string rw);
    chk(npw == (len + 3) / 4, rw, npw, (len + 3) / 4);
    for (int k = 0; k < (len + 3) / 4 && k < npw; k++)
      chk(pw[k] == exp_word(k, len), rw, pw[k], exp_word(k, len));
    chk(nhw == 1 && order_bad == 0, "R3", nhw + 16*order_bad, 1);
    chk(hw == {8'h00, 8'(len >> 8), 8'(len), dt}, "R4", hw, {8'h00, 8'(len >> 8), 8'(len), dt});
    chk(ndone == 1 && nerr == 0, "R6", ndone + 16*nerr, 1);
  endtask

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    logic [7:0] sh [0:9];
    int len, d, arg;
    void'($urandom(32'd7));
    sh[0]=8'h03; sh[1]=8'h13; sh[2]=8'h23; sh[3]=8'h05; sh[4]=8'h15;
    sh[5]=8'h37; sh[6]=8'h02; sh[7]=8'h12; sh[8]=8'h22; sh[9]=8'h32;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready && !busy && !byte_ready && !pl_wr && !hdr_wr && !done && !err, "R11",
        {req_ready, busy, byte_ready, pl_wr, hdr_wr, done, err}, 7'b1000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 directed lengths 1..5, R10 stall on accept
    for (int l = 1; l <= 5; l++) begin
      do_req(8'h39, l, l, 3, 1'b0);
      check_long(8'h39, l, (l % 4 == 0) ? "R1" : "R2");
      chk(acc_rdy == 0 && acc_busy == 1, "R10", acc_rdy, 0);
    end
    // R4 high count byte
    do_req(8'h29, 260, 260, 5, 1'b1);
    check_long(8'h29, 260, "R1");
    // R12 zero length
    do_req(8'h29, 0, 0, 2, 1'b0);
    chk(npw == 0 && hw == 32'h0000_0029, "R12", hw, 32'h29);
    chk(ndone == 1 && nerr == 0, "R12", ndone, 1);
    // R6 boundary: event in last allowed wait cycle
    do_req(8'h39, 7, 7, LIM - 1, 1'b0);
    check_long(8'h39, 7, "R2");
    // R7 timeout
    do_req(8'h39, 6, 6, -1, 1'b0);
    chk(nerr == 1 && ecode == 2'd3 && ndone == 0, "R7", {ecode, 4'(ndone)}, 6'h30);
    chk(err_cyc - hdr_cyc == LIM, "R7", err_cyc - hdr_cyc, LIM);
    // R5 every short type
    for (int s = 0; s < 10; s++) begin
      arg = int'($urandom % 65536);
      do_req(sh[s], arg, 0, -1, 1'b0);
      chk(npw == 0 && nhw == 1 && hw == {8'h00, 8'(arg >> 8), 8'(arg), sh[s]}, "R5",
          hw, {8'h00, 8'(arg >> 8), 8'(arg), sh[s]});
      chk(ndone == 1 && nerr == 0 && hdr_cyc != 0, "R5", ndone, 1);
    end
    // R8 ULPS reject
    link_ulps = 1'b1;
    do_req(8'h29, 8, 0, -1, 1'b0);
    chk(nerr == 1 && ecode == 2'd1 && npw == 0 && nhw == 0 && ndone == 0, "R8", ecode, 1);
    do_req(8'h05, 8, 0, -1, 1'b0);
    chk(nerr == 1 && ecode == 2'd1 && nhw == 0, "R8", ecode, 1);
    link_ulps = 1'b0;
    // R9 unsupported types
    do_req(8'h09, 4, 0, -1, 1'b0);
    chk(nerr == 1 && ecode == 2'd2 && npw == 0 && nhw == 0 && ndone == 0, "R9", ecode, 2);
    do_req(8'h1A, 4, 0, -1, 1'b0);
    chk(nerr == 1 && ecode == 2'd2 && nhw == 0, "R9", ecode, 2);
    // random long writes
    for (int r = 0; r < 30; r++) begin
      len = int'($urandom % 40);
      d = 1 + int'($urandom % (LIM - 1));
      do_req((r % 2) ? 8'h29 : 8'h39, len, len, d, 1'($urandom));
      check_long((r % 2) ? 8'h29 : 8'h39, len, "R1");
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule